// File: doc/BRIEF.md
# Scatter-Gather Receive Descriptor Filler

This engine takes packets arriving on a valid/ready stream and spreads them over a linked chain of descriptors held in memory. For each descriptor it fetches four words: the next pointer, the buffer address, the buffer length and the status. It then writes incoming beats into the buffer until the buffer is full or the packet ends. After that it writes the status word back and follows the next pointer. The first descriptor of a packet is flagged as the start. The descriptor that finishes the packet is flagged as the end and receives five application words. Those five words were captured earlier from a separate side stream.

Software, or a register block beside the engine, loads the current descriptor pointer and moves the tail pointer. The engine stops after it has processed the tail descriptor, and reports idle. It also stops if it fetches a descriptor that is already marked complete, and reports halted. While the channel is not running, is idle or is halted, the stream input is held off. Each finished packet raises a single-cycle completion pulse for the interrupt logic downstream.

Lengths are counted in 32-bit beats. Buffer beat k is written at the buffer address plus 4*k.

Top module: `s2m_desc_filler`

## Requirements
- R1: Descriptor layout, at byte offsets from the descriptor address: +0 next pointer, +4 buffer address, +8 length in bits 22:0, +12 status, +16..+32 five application words. Each descriptor receives min(its length, beats left in the packet), written in arrival order.
- R2: Every status writeback has bit 31 (complete) set and holds the number of beats stored in that buffer in bits 22:0. Bits 30:28 and 25:23 are zero.
- R3: Status bit 27 (start) is set only on the first descriptor of a packet, including after a pause at the tail.
- R4: Only the descriptor that receives the last beat of a packet gets status bit 26 (end). That descriptor also gets the five committed application words at +16..+32, and cmpl_o pulses exactly once for the packet.
- R5: A fetched descriptor whose status bit 31 is already set raises halted_o. No beat is then accepted and no buffer is written.
- R6: After the tail descriptor is written back, idle_o rises and s_ready_o stays low. A later tail_set_i clears idle_o, and the rest of the same packet continues into the next descriptor.
- R7: s_ready_o is low whenever run_i is low. Raising run_i lets the pending fetch and the reception go ahead.
- R8: A side-stream packet commits its words only if it is exactly five words long, ending with ctl_last_i. Any other length pulses ctl_err_o in the cycle after the last word and leaves the committed words unchanged.
- R9: If tail_set_i arrives in the same cycle as the status writeback of the old tail, the new tail value decides. The engine does not go idle and carries on.
- R10: After reset: halted_o=1, idle_o=0, s_ready_o=0, mem_req_o=0, cmpl_o=0, ctl_err_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Channel running |
| cur_load_i | input | 1 | Load current descriptor pointer; clears halted and idle |
| cur_addr_i | input | AW | Current descriptor address |
| tail_set_i | input | 1 | Update tail pointer; clears idle |
| tail_addr_i | input | AW | Tail descriptor address |
| s_valid_i | input | 1 | Data beat valid |
| s_data_i | input | 32 | Data beat |
| s_last_i | input | 1 | Last beat of packet |
| s_ready_o | output | 1 | Data beat accepted |
| ctl_valid_i | input | 1 | Side-stream word valid |
| ctl_data_i | input | 32 | Side-stream application word |
| ctl_last_i | input | 1 | Last side-stream word |
| ctl_err_o | output | 1 | Side-stream length error pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory request accepted; read data valid |
| mem_rdata_i | input | 32 | Memory read data |
| cmpl_o | output | 1 | Packet completion pulse |
| idle_o | output | 1 | Tail reached |
| halted_o | output | 1 | Stopped on a completed descriptor |

## Verification
The bench targets one same-cycle collision: the status writeback of the current tail descriptor and a tail update from software. A watcher process waits until it sees the write to the old tail's status address on the memory port. It then drives tail_set_i in that same cycle. The bench judges the result in three ways: idle_o must still be low one cycle later, the second descriptor must carry the end flag with the expected length, and the first descriptor must carry the start flag with no end flag.

// File: rtl/s2m_pkg.sv
package s2m_pkg;
  localparam int WORD_W      = 32;
  localparam int APP_WORDS   = 5;
  localparam int ST_DONE_BIT = 31;
  localparam int ST_SOF_BIT  = 27;
  localparam int ST_EOF_BIT  = 26;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_NEXT,
    S_RD_BUF,
    S_RD_LEN,
    S_RD_STS,
    S_DATA,
    S_WR_APP,
    S_WR_STS
  } walk_state_e;
endpackage

// File: rtl/s2m_app_capture.sv
module s2m_app_capture
  import s2m_pkg::*;
#(
  parameter int NW = APP_WORDS,
  parameter int W  = WORD_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [W-1:0]          data_i,
  input  logic                  last_i,
  output logic [NW-1:0][W-1:0]  app_o,
  output logic                  err_o
);
  localparam int CW = $clog2(NW + 1);

  logic [CW-1:0]         idx_q;
  logic [NW-1:0][W-1:0]  stage_q;
  logic [NW-1:0][W-1:0]  app_q;
  logic                  err_q;
  logic                  commit;

  assign commit = valid_i && last_i && (idx_q == CW'(NW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      stage_q <= '0;
      app_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= valid_i && last_i && (idx_q != CW'(NW - 1));
      if (valid_i) begin
        for (int w = 0; w < NW; w++)
          if (idx_q == CW'(w)) stage_q[w] <= data_i;
        if (last_i)                 idx_q <= '0;
        else if (idx_q != CW'(NW))  idx_q <= idx_q + CW'(1);
      end
      if (commit)
        for (int w = 0; w < NW; w++)
          app_q[w] <= (idx_q == CW'(w)) ? data_i : stage_q[w];
    end
  end

  assign app_o = app_q;
  assign err_o = err_q;

  // R8: error only after a terminating word, and never alters committed words
  assert_err_after_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(valid_i && last_i));
  assert_err_keeps_app_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(app_o));
endmodule

// File: rtl/s2m_walker.sv
module s2m_walker
  import s2m_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 23,
  parameter int NW = APP_WORDS
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       run_i,
  input  logic                       cur_load_i,
  input  logic [AW-1:0]              cur_addr_i,
  input  logic                       tail_set_i,
  input  logic [AW-1:0]              tail_addr_i,
  input  logic                       s_valid_i,
  input  logic [WORD_W-1:0]          s_data_i,
  input  logic                       s_last_i,
  output logic                       s_ready_o,
  input  logic [NW-1:0][WORD_W-1:0]  app_i,
  output logic                       mem_req_o,
  output logic                       mem_we_o,
  output logic [AW-1:0]              mem_addr_o,
  output logic [WORD_W-1:0]          mem_wdata_o,
  input  logic                       mem_ack_i,
  input  logic [WORD_W-1:0]          mem_rdata_i,
  output logic                       cmpl_o,
  output logic                       idle_o,
  output logic                       halted_o
);
  localparam int IW = $clog2(NW);

  walk_state_e   st_q;
  logic [AW-1:0] cur_q, tail_q, next_q, buf_q;
  logic [LW-1:0] len_q, cnt_q;
  logic [IW-1:0] app_idx_q;
  logic          sof_q, eof_q, idle_q, halted_q, cmpl_q;

  logic [AW-1:0]     tail_eff;
  logic [WORD_W-1:0] sts_word;
  logic              beat_ok, beat_end;

  assign tail_eff = tail_set_i ? tail_addr_i : tail_q;
  assign s_ready_o = (st_q == S_DATA) && run_i && mem_ack_i;
  assign beat_ok   = s_valid_i && s_ready_o;
  assign beat_end  = s_last_i || ((cnt_q + LW'(1)) == len_q);

  always_comb begin
    sts_word = '0;
    sts_word[LW-1:0]    = cnt_q;
    sts_word[ST_DONE_BIT] = 1'b1;
    sts_word[ST_SOF_BIT]  = sof_q;
    sts_word[ST_EOF_BIT]  = eof_q;
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur_q;
    mem_wdata_o = '0;
    unique case (st_q)
      S_RD_NEXT: mem_req_o = 1'b1;
      S_RD_BUF: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + AW'(4);
      end
      S_RD_LEN: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + AW'(8);
      end
      S_RD_STS: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + AW'(12);
      end
      S_DATA: begin
        mem_req_o   = s_valid_i && run_i;
        mem_we_o    = 1'b1;
        mem_addr_o  = buf_q + AW'({cnt_q, 2'b00});
        mem_wdata_o = s_data_i;
      end
      S_WR_APP: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_q + AW'(16) + AW'({app_idx_q, 2'b00});
        mem_wdata_o = app_i[app_idx_q];
      end
      S_WR_STS: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_q + AW'(12);
        mem_wdata_o = sts_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      cur_q     <= '0;
      tail_q    <= '0;
      next_q    <= '0;
      buf_q     <= '0;
      len_q     <= '0;
      cnt_q     <= '0;
      app_idx_q <= '0;
      sof_q     <= 1'b1;
      eof_q     <= 1'b0;
      idle_q    <= 1'b0;
      halted_q  <= 1'b1;
      cmpl_q    <= 1'b0;
    end else begin
      cmpl_q <= 1'b0;
      if (tail_set_i) tail_q <= tail_addr_i;
      if (tail_set_i || cur_load_i) idle_q <= 1'b0;
      unique case (st_q)
        S_IDLE:
          if (run_i && !idle_q && !halted_q && !cur_load_i) st_q <= S_RD_NEXT;
        S_RD_NEXT:
          if (mem_ack_i) begin
            next_q <= mem_rdata_i[AW-1:0];
            st_q   <= S_RD_BUF;
          end
        S_RD_BUF:
          if (mem_ack_i) begin
            buf_q <= mem_rdata_i[AW-1:0];
            st_q  <= S_RD_LEN;
          end
        S_RD_LEN:
          if (mem_ack_i) begin
            len_q <= mem_rdata_i[LW-1:0];
            st_q  <= S_RD_STS;
          end
        S_RD_STS:
          if (mem_ack_i) begin
            cnt_q <= '0;
            eof_q <= 1'b0;
            if (mem_rdata_i[ST_DONE_BIT]) begin
              halted_q <= 1'b1;
              st_q     <= S_IDLE;
            end else if (len_q == '0) begin
              st_q <= S_WR_STS;
            end else begin
              st_q <= S_DATA;
            end
          end
        S_DATA:
          if (beat_ok) begin
            cnt_q <= cnt_q + LW'(1);
            if (beat_end) begin
              eof_q     <= s_last_i;
              app_idx_q <= '0;
              st_q      <= s_last_i ? S_WR_APP : S_WR_STS;
            end
          end
        S_WR_APP:
          if (mem_ack_i) begin
            app_idx_q <= app_idx_q + IW'(1);
            if (app_idx_q == IW'(NW - 1)) st_q <= S_WR_STS;
          end
        S_WR_STS:
          if (mem_ack_i) begin
            cmpl_q <= eof_q;
            sof_q  <= eof_q;
            eof_q  <= 1'b0;
            cur_q  <= next_q;
            if (cur_q == tail_eff) begin
              idle_q <= 1'b1;
              st_q   <= S_IDLE;
            end else begin
              st_q <= S_RD_NEXT;
            end
          end
        default: st_q <= S_IDLE;
      endcase
      if (cur_load_i) begin
        cur_q    <= cur_addr_i;
        halted_q <= 1'b0;
      end
    end
  end

  assign cmpl_o   = cmpl_q;
  assign idle_o   = idle_q;
  assign halted_o = halted_q;

  assert_fill_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_ok |-> (cnt_q < len_q));
  assert_sof_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_WR_STS && mem_ack_i && !eof_q) |=> !sof_q);
  assert_cmpl_after_eof_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_o |-> $past(st_q == S_WR_STS && eof_q));
  assert_halt_stops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |-> (st_q == S_IDLE));
  assert_ready_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> (!idle_q && !halted_q));
  assert_idle_after_wb_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_q) |-> $past(st_q == S_WR_STS));
  assert_tail_race_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_WR_STS && mem_ack_i && tail_set_i && cur_q != tail_addr_i && !cur_load_i)
      |=> !idle_q);
endmodule

// File: rtl/s2m_desc_filler.sv
module s2m_desc_filler
  import s2m_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              cur_load_i,
  input  logic [AW-1:0]     cur_addr_i,
  input  logic              tail_set_i,
  input  logic [AW-1:0]     tail_addr_i,
  input  logic              s_valid_i,
  input  logic [WORD_W-1:0] s_data_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  input  logic              ctl_valid_i,
  input  logic [WORD_W-1:0] ctl_data_i,
  input  logic              ctl_last_i,
  output logic              ctl_err_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              cmpl_o,
  output logic              idle_o,
  output logic              halted_o
);
  logic [APP_WORDS-1:0][WORD_W-1:0] app_words;

  s2m_app_capture #(.NW(APP_WORDS), .W(WORD_W)) u_app (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (ctl_valid_i),
    .data_i  (ctl_data_i),
    .last_i  (ctl_last_i),
    .app_o   (app_words),
    .err_o   (ctl_err_o)
  );

  s2m_walker #(.AW(AW), .LW(LW), .NW(APP_WORDS)) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_i),
    .cur_load_i  (cur_load_i),
    .cur_addr_i  (cur_addr_i),
    .tail_set_i  (tail_set_i),
    .tail_addr_i (tail_addr_i),
    .s_valid_i   (s_valid_i),
    .s_data_i    (s_data_i),
    .s_last_i    (s_last_i),
    .s_ready_o   (s_ready_o),
    .app_i       (app_words),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .cmpl_o      (cmpl_o),
    .idle_o      (idle_o),
    .halted_o    (halted_o)
  );
endmodule

// File: tb/sim_s2m_desc_filler.sv
`timescale 1ns/1ps
module sim_s2m_desc_filler;
  localparam int AW = 32;
  localparam int NV = 6;
  // d0 len, d1 len, d2 len, packet beats
  localparam int VEC [NV][4] = '{
    '{4, 4, 4, 3}, '{4, 4, 4, 4}, '{4, 4, 4, 5},
    '{2, 3, 8, 12}, '{1, 1, 1, 3}, '{16, 4, 4, 9}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic run = 1'b1, cur_load = 1'b0, tail_set = 1'b0;
  logic [AW-1:0] cur_addr = '0, tail_addr = '0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic [31:0] s_data = '0;
  logic s_ready;
  logic ctl_valid = 1'b0, ctl_last = 1'b0;
  logic [31:0] ctl_data = '0;
  logic ctl_err;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic cmpl, idle, halted;

  logic [31:0] mem [0:255];
  logic tb_we = 1'b0;
  logic [7:0] tb_a = '0;
  logic [31:0] tb_d = '0;
  int cmpl_cnt = 0;
  int nchk = 0, nerr = 0;
  int cyc = 0;

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) begin
    if (tb_we) mem[tb_a] <= tb_d;
    else if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (cmpl) cmpl_cnt <= cmpl_cnt + 1;
  end

  s2m_desc_filler u0 (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run),
    .cur_load_i(cur_load), .cur_addr_i(cur_addr),
    .tail_set_i(tail_set), .tail_addr_i(tail_addr),
    .s_valid_i(s_valid), .s_data_i(s_data), .s_last_i(s_last), .s_ready_o(s_ready),
    .ctl_valid_i(ctl_valid), .ctl_data_i(ctl_data), .ctl_last_i(ctl_last), .ctl_err_o(ctl_err),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(1'b1), .mem_rdata_i(mem_rdata),
    .cmpl_o(cmpl), .idle_o(idle), .halted_o(halted)
  );

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nerr++;
        $display("FAIL watchdog: act=hung exp=done");
        $display("Simulation finished: %0d checks, %0d errors", nchk + 1, nerr);
        $finish;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic mw(input int a, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_a = 8'(a); tb_d = d;
  endtask

  task automatic mw_end();
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  // descriptor i at byte 64*i, buffer at byte 512+64*i
  task automatic set_desc(input int i, input int len, input int nxt);
    mw(16*i + 0, 32'(nxt * 64));
    mw(16*i + 1, 32'(512 + 64*i));
    mw(16*i + 2, 32'(len));
    mw(16*i + 3, 32'h0);
    for (int j = 0; j < 5; j++) mw(16*i + 4 + j, 32'h0);
  endtask

  task automatic load(input int cur_b, input int tail_b);
    @(negedge clk);
    cur_load = 1'b1; cur_addr = 32'(cur_b);
    tail_set = 1'b1; tail_addr = 32'(tail_b);
    @(negedge clk);
    cur_load = 1'b0; tail_set = 1'b0;
  endtask

  task automatic send_ctl(input int n, input logic [31:0] base, output logic err);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      ctl_valid = 1'b1; ctl_data = base + 32'(j); ctl_last = (j == n - 1);
    end
    @(negedge clk);
    ctl_valid = 1'b0; ctl_last = 1'b0;
    err = ctl_err;
  endtask

  task automatic send_pkt(input int n, input logic [31:0] seed);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = seed + 32'(k); s_last = (k == n - 1);
      while (!s_ready) @(negedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic wait_stop();
    while (!idle && !halted) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic err;
    int lens [3];
    int pkt, t, rem, off, n, c0;
    logic seen;

    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 halted", 32'(halted), 32'd1);
    check("R10 idle", 32'(idle), 32'd0);
    check("R10 ready", 32'(s_ready), 32'd0);
    check("R10 mem_req", 32'(mem_req), 32'd0);
    check("R10 cmpl/err", 32'({cmpl, ctl_err}), 32'd0);
    rst_n = 1'b1;

    // table-driven packets: R1 R2 R3 R4 R8
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < 3; i++) begin
        lens[i] = VEC[v][i];
        set_desc(i, lens[i], i + 1);
      end
      mw_end();
      pkt = VEC[v][3];
      rem = pkt; t = 0;
      for (int i = 0; i < 3; i++) begin
        if (rem <= lens[i]) begin t = i; break; end
        rem -= lens[i];
      end
      send_ctl(5, 32'hA000_0000 + 32'(v * 16), err);
      check("R8 good ctl no err", 32'(err), 32'd0);
      c0 = cmpl_cnt;
      load(0, t * 64);
      send_pkt(pkt, 32'(v * 256));
      wait_stop();
      check("R6 idle at tail", 32'(idle), 32'd1);
      rem = pkt; off = 0;
      for (int i = 0; i <= t; i++) begin
        n = (lens[i] < rem) ? lens[i] : rem;
        check("R2 R3 R4 status", mem[16*i + 3],
              32'h8000_0000 | (i == 0 ? 32'h0800_0000 : 32'h0) |
              (i == t ? 32'h0400_0000 : 32'h0) | 32'(n));
        for (int k = 0; k < n; k++)
          check("R1 buffer data", mem[128 + 16*i + k], 32'(v * 256 + off + k));
        off += n; rem -= n;
      end
      for (int j = 0; j < 5; j++)
        check("R4 app word", mem[16*t + 4 + j], 32'hA000_0000 + 32'(v * 16 + j));
      check("R4 one cmpl", 32'(cmpl_cnt - c0), 32'd1);
    end

    // R5 completed descriptor halts
    set_desc(0, 4, 1);
    mw(3, 32'h8000_0000);
    mw(128, 32'hDEAD_BEEF);
    mw_end();
    load(0, 0);
    @(negedge clk);
    s_valid = 1'b1; s_data = 32'h1; s_last = 1'b1;
    seen = 1'b0;
    repeat (20) begin @(negedge clk); seen |= s_ready; end
    s_valid = 1'b0; s_last = 1'b0;
    check("R5 halted", 32'(halted), 32'd1);
    check("R5 no ready", 32'(seen), 32'd0);
    check("R5 buffer untouched", mem[128], 32'hDEAD_BEEF);

    // R7 not running
    run = 1'b0;
    set_desc(0, 4, 1);
    mw(128, 32'hCAFE_0000);
    mw_end();
    load(0, 0);
    @(negedge clk);
    s_valid = 1'b1; s_data = 32'h2; s_last = 1'b1;
    seen = 1'b0;
    repeat (20) begin @(negedge clk); seen |= s_ready; end
    s_valid = 1'b0; s_last = 1'b0;
    check("R7 no ready while stopped", 32'(seen), 32'd0);
    check("R7 buffer untouched", mem[128], 32'hCAFE_0000);
    run = 1'b1;
    send_ctl(5, 32'hB000_0000, err);
    send_pkt(4, 32'h700);
    wait_stop();
    check("R7 resumes status", mem[3], 32'h8C00_0004);
    check("R7 resumes data", mem[128], 32'h700);

    // R8 bad side-stream lengths
    send_ctl(4, 32'hC000_0000, err);
    check("R8 short ctl err", 32'(err), 32'd1);
    send_ctl(6, 32'hD000_0000, err);
    check("R8 long ctl err", 32'(err), 32'd1);
    set_desc(0, 4, 1);
    mw_end();
    load(0, 0);
    send_pkt(2, 32'h900);
    wait_stop();
    check("R8 status", mem[3], 32'h8C00_0002);
    for (int j = 0; j < 5; j++)
      check("R8 app kept", mem[4 + j], 32'hB000_0000 + 32'(j));

    // R6 chain exhausted mid-packet, then tail extended
    for (int i = 0; i < 3; i++) set_desc(i, 4, i + 1);
    mw_end();
    load(0, 64);
    fork
      send_pkt(10, 32'h1000);
      begin
        while (!idle) @(negedge clk);
        repeat (5) @(negedge clk);
        check("R6 ready low when idle", 32'(s_ready), 32'd0);
        check("R6 mid status", mem[16 + 3], 32'h8000_0004);
        tail_set = 1'b1; tail_addr = 32'd128;
        @(negedge clk);
        tail_set = 1'b0;
      end
    join
    wait_stop();
    check("R6 first status", mem[3], 32'h8800_0004);
    check("R3 R6 resumed status", mem[32 + 3], 32'h8400_0002);
    check("R6 resumed data", mem[160], 32'h1008);

    // R9 tail update in the same cycle as old-tail writeback
    for (int i = 0; i < 2; i++) set_desc(i, 4, i + 1);
    mw_end();
    load(0, 0);
    fork
      send_pkt(8, 32'h2000);
      begin
        while (!(mem_req && mem_we && mem_addr == 32'd12)) @(negedge clk);
        tail_set = 1'b1; tail_addr = 32'd64;
        @(negedge clk);
        tail_set = 1'b0;
        check("R9 no idle on race", 32'(idle), 32'd0);
      end
    join
    wait_stop();
    check("R9 first status", mem[3], 32'h8800_0004);
    check("R9 second status", mem[16 + 3], 32'h8400_0004);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule